// File: doc/BRIEF.md
# Serial Flash Whole-Array Erase Command Engine

This block is the slave-side command front end of a small serial flash model. A host drives chip select, serial clock and serial data in (SPI mode 0), and reads a status byte back on serial data out. Three commands are understood: set the write-enable latch, read status, and erase the whole array. The erase command has two opcodes that behave identically.

An erase is accepted only when chip select returns high on a whole-byte boundary after at least one complete opcode. The write-enable latch must be set and no sector may be flagged as protected. An accepted erase runs for a parameterised number of system clock cycles and then fills every word of an internal register array with ones. While it runs, the host polls the status byte to see the busy flag. A test input can force the erase to report a failure through the error flag.

The SPI lines are sampled by the system clock through synchronisers, so the serial clock must be several times slower than the system clock. A registered peek port reads the array so that the effect of an erase can be observed.

Top module: `flash_erase_engine`

## Requirements
- R1: After reset the status byte reads 00h and every array word reads zero through the peek port.
- R2: Opcode 06h, ended on a byte boundary while idle, sets the write-enable latch, which is status bit 1.
- R3: Opcode 60h, ended on a byte boundary with the latch set and no protection, launches an erase. Status then shows busy (bit 0) with the latch still set. After ERASE_CYCLES clocks, busy and the latch both read 0 and every array word reads all ones.
- R4: Opcode C7h behaves exactly like 60h.
- R5: An erase opcode sent while the latch is clear does nothing: the status stays 00h and the array is unchanged.
- R6: If chip select rises after fewer than 8 bits, or after a bit count that is not a multiple of 8, no erase starts and the latch keeps its value.
- R7: Whole bytes sent after an erase opcode are ignored, and the erase still launches.
- R8: If any sector_prot bit is 1 when an erase opcode is accepted, no erase starts, the latch clears, and the array is unchanged.
- R9: When erase_fail_inj is 1 as an erase completes, the error flag (status bit 5) becomes 1. The next launched erase clears it.
- R10: While busy, every command except read status is ignored: a second erase opcode neither restarts nor extends the running erase.
- R11: Read status (05h) returns the status byte MSB first, with bits changing after falling SCK edges. The byte repeats for each further byte clocked while chip select stays low. MISO is 0 while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host (status byte) |
| sector_prot | input | NSEC | Per-sector protection flags, 1 = protected |
| erase_fail_inj | input | 1 | Test input: erase reports failure at completion |
| peek_addr | input | $clog2(WORDS) | Array word to observe |
| peek_data | output | DATA_W | Registered contents of the selected word |

## Verification
A wrong latch or busy state shows on the next status poll. For example, a busy flag that stays set or clears early is seen by polling just before and just after the expected completion cycle. A restarted timer is exposed by a poll made after the first erase should have ended. A mis-counted bit position at chip-select release either launches an erase that should not run or skips one that should. That difference shows within one status read, because busy rises within a few cycles of chip select going high. The peek port confirms within two cycles that rejected erases leave the array untouched and completed ones fill it with ones.

// File: rtl/fe_pkg.sv
package fe_pkg;
  localparam logic [7:0] OP_WREN    = 8'h06;
  localparam logic [7:0] OP_RDSR    = 8'h05;
  localparam logic [7:0] OP_ERASE_A = 8'h60;
  localparam logic [7:0] OP_ERASE_B = 8'hC7;

  localparam int ST_BUSY = 0;
  localparam int ST_WEL  = 1;
  localparam int ST_EPE  = 5;

  // Summary of a finished chip-select frame
  typedef struct packed {
    logic       valid;    // one-cycle pulse when chip select rises
    logic       aligned;  // bit count is a multiple of eight
    logic       has_op;   // at least one full byte arrived
    logic [7:0] op;       // first byte of the frame
  } frame_end_t;
endpackage

// File: rtl/fe_spi_port.sv
module fe_spi_port
  import fe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       csn,
  input  logic       sck,
  input  logic       mosi,
  input  logic [7:0] status,
  output frame_end_t frame,
  output logic       miso
);
  logic [SYNC_STAGES-1:0] csn_sr, sck_sr, mosi_sr;
  logic csn_s, sck_s, mosi_s, csn_d, sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      csn_sr  <= '1;
      sck_sr  <= '0;
      mosi_sr <= '0;
      csn_d   <= 1'b1;
      sck_d   <= 1'b0;
    end else begin
      csn_sr  <= {csn_sr[SYNC_STAGES-2:0], csn};
      sck_sr  <= {sck_sr[SYNC_STAGES-2:0], sck};
      mosi_sr <= {mosi_sr[SYNC_STAGES-2:0], mosi};
      csn_d   <= csn_s;
      sck_d   <= sck_s;
    end
  end

  assign csn_s  = csn_sr[SYNC_STAGES-1];
  assign sck_s  = sck_sr[SYNC_STAGES-1];
  assign mosi_s = mosi_sr[SYNC_STAGES-1];

  logic sck_rise, sck_fall, cs_fall, cs_rise;
  assign sck_rise = !csn_s && sck_s && !sck_d;
  assign sck_fall = !csn_s && !sck_s && sck_d;
  assign cs_fall  = !csn_s && csn_d;
  assign cs_rise  = csn_s && !csn_d;

  logic [2:0] bit_cnt;
  logic       has_op;
  logic [7:0] op;
  logic [6:0] rx_sh;
  logic [6:0] tx_sh;
  logic       rd_mode;

  assign rd_mode = has_op && (op == OP_RDSR);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      has_op  <= 1'b0;
      op      <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      miso    <= 1'b0;
      frame   <= '0;
    end else begin
      frame.valid   <= cs_rise;
      frame.aligned <= (bit_cnt == 3'd0);
      frame.has_op  <= has_op;
      frame.op      <= op;
      if (cs_fall) begin
        bit_cnt <= '0;
        has_op  <= 1'b0;
      end else if (sck_rise) begin
        bit_cnt <= bit_cnt + 3'd1;
        if (!has_op) begin
          rx_sh <= {rx_sh[5:0], mosi_s};
          if (bit_cnt == 3'd7) begin
            op     <= {rx_sh, mosi_s};
            has_op <= 1'b1;
          end
        end
      end
      if (csn_s) begin
        miso <= 1'b0;
      end else if (sck_fall && rd_mode) begin
        if (bit_cnt == 3'd0) begin
          miso  <= status[7];
          tx_sh <= status[6:0];
        end else begin
          miso  <= tx_sh[6];
          tx_sh <= {tx_sh[5:0], 1'b0};
        end
      end
    end
  end

  // R11
  miso_idle_chk: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> !miso);
endmodule

// File: rtl/fe_ctrl.sv
module fe_ctrl
  import fe_pkg::*;
#(
  parameter int NSEC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  frame_end_t      frame,
  input  logic [NSEC-1:0] prot,
  input  logic            done,
  input  logic            fail_inj,
  output logic            start,
  output logic [7:0]      status
);
  logic busy_q, wel_q, epe_q;
  logic accept;

  assign accept = frame.valid && frame.aligned && frame.has_op && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      wel_q  <= 1'b0;
      epe_q  <= 1'b0;
      start  <= 1'b0;
    end else begin
      start <= 1'b0;
      if (accept) begin
        case (frame.op)
          OP_WREN: wel_q <= 1'b1;
          OP_ERASE_A, OP_ERASE_B: begin
            if (wel_q) begin
              if (prot == '0) begin
                start  <= 1'b1;
                busy_q <= 1'b1;
                epe_q  <= 1'b0;
              end else begin
                wel_q <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
      if (done) begin
        busy_q <= 1'b0;
        wel_q  <= 1'b0;
        epe_q  <= fail_inj;
      end
    end
  end

  always_comb begin
    status          = '0;
    status[ST_BUSY] = busy_q;
    status[ST_WEL]  = wel_q;
    status[ST_EPE]  = epe_q;
  end

  // R3
  launch_needs_wel_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(wel_q));
  // R8
  launch_needs_unprot_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(prot == '0));
  // R3
  wel_clear_on_finish_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> !wel_q);
endmodule

// File: rtl/fe_erase_array.sv
module fe_erase_array #(
  parameter int WORDS        = 16,
  parameter int DATA_W       = 8,
  parameter int ERASE_CYCLES = 4000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [$clog2(WORDS)-1:0] peek_addr,
  output logic                     done,
  output logic [DATA_W-1:0]        peek_data
);
  localparam int CW = $clog2(ERASE_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(ERASE_CYCLES - 1);

  logic [CW-1:0]     cnt;
  logic              run;
  logic              wipe;
  logic [DATA_W-1:0] mem [WORDS];

  assign wipe = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= wipe;
      if (start) begin
        run <= 1'b1;
        cnt <= '0;
      end else if (wipe) begin
        run <= 1'b0;
      end else if (run) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < WORDS; i++) begin
      if (rst)       mem[i] <= '0;
      else if (wipe) mem[i] <= '1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) peek_data <= '0;
    else     peek_data <= mem[peek_addr];
  end

  // R10
  no_relaunch_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !run);
  // R10
  run_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !wipe) |=> run);
endmodule

// File: rtl/flash_erase_engine.sv
module flash_erase_engine
  import fe_pkg::*;
#(
  parameter int NSEC         = 8,
  parameter int WORDS        = 16,
  parameter int DATA_W       = 8,
  parameter int ERASE_CYCLES = 4000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     spi_csn,
  input  logic                     spi_sck,
  input  logic                     spi_mosi,
  output logic                     spi_miso,
  input  logic [NSEC-1:0]          sector_prot,
  input  logic                     erase_fail_inj,
  input  logic [$clog2(WORDS)-1:0] peek_addr,
  output logic [DATA_W-1:0]        peek_data
);
  frame_end_t frame;
  logic [7:0] status;
  logic       start, done;

  fe_spi_port #(.SYNC_STAGES(SYNC_STAGES)) u_port (
    .clk(clk), .rst(rst), .csn(spi_csn), .sck(spi_sck), .mosi(spi_mosi),
    .status(status), .frame(frame), .miso(spi_miso)
  );

  fe_ctrl #(.NSEC(NSEC)) u_ctrl (
    .clk(clk), .rst(rst), .frame(frame), .prot(sector_prot), .done(done),
    .fail_inj(erase_fail_inj), .start(start), .status(status)
  );

  fe_erase_array #(.WORDS(WORDS), .DATA_W(DATA_W), .ERASE_CYCLES(ERASE_CYCLES)) u_array (
    .clk(clk), .rst(rst), .start(start), .peek_addr(peek_addr),
    .done(done), .peek_data(peek_data)
  );
endmodule

// File: tb/flash_erase_engine_tb.sv
module flash_erase_engine_tb;
  localparam int NSEC = 8, WORDS = 16, DATA_W = 8, EC = 4000, HP = 8;
  localparam int AW = $clog2(WORDS);

  logic clk = 0, rst = 1;
  logic csn = 1, sck = 0, mosi = 0, miso;
  logic [NSEC-1:0] prot = '0;
  logic inj = 0;
  logic [AW-1:0] paddr = '0;
  logic [DATA_W-1:0] pdata;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] rx_byte;
  event rx_ev;

  always #2.5 clk = ~clk;

  flash_erase_engine #(.NSEC(NSEC), .WORDS(WORDS), .DATA_W(DATA_W), .ERASE_CYCLES(EC)) u_dut (
    .clk(clk), .rst(rst), .spi_csn(csn), .spi_sck(sck), .spi_mosi(mosi), .spi_miso(miso),
    .sector_prot(prot), .erase_fail_inj(inj), .peek_addr(paddr), .peek_data(pdata)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares each received status byte against the queue
  initial forever begin
    @(rx_ev);
    if (exp_q.size() == 0) check(0, "queue-empty", rx_byte, 0);
    else begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(rx_byte == e, t, rx_byte, e);
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_frame(input logic [31:0] data, input int nbits, output logic [31:0] rx);
    rx = '0;
    csn = 0;
    wait_clk(HP);
    for (int i = nbits - 1; i >= 0; i--) begin
      mosi = data[i];
      wait_clk(HP);
      sck = 1;
      rx = {rx[30:0], miso};
      wait_clk(HP);
      sck = 0;
    end
    wait_clk(HP);
    csn = 1;
    mosi = 0;
    wait_clk(2 * HP);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [31:0] r;
    spi_frame({24'h0, op}, 8, r);
  endtask

  task automatic read_status(input logic [7:0] exp, input string tag);
    logic [31:0] r;
    exp_q.push_back(exp); tag_q.push_back(tag);
    spi_frame(32'h0500, 16, r);
    rx_byte = r[7:0]; -> rx_ev;
    wait_clk(1);
  endtask

  task automatic read_status2(input logic [7:0] exp, input string tag);
    logic [31:0] r;
    exp_q.push_back(exp); tag_q.push_back({tag, " byte1"});
    exp_q.push_back(exp); tag_q.push_back({tag, " byte2"});
    spi_frame(32'h050000, 24, r);
    rx_byte = r[15:8]; -> rx_ev;
    wait_clk(1);
    rx_byte = r[7:0]; -> rx_ev;
    wait_clk(1);
  endtask

  task automatic peek(input int a, input logic [DATA_W-1:0] exp, input string tag);
    paddr = AW'(a);
    wait_clk(2);
    check(pdata == exp, tag, pdata, exp);
  endtask

  task automatic do_reset();
    rst = 1; wait_clk(4); rst = 0; wait_clk(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    do_reset();
    // R1 reset state
    check(miso == 1'b0, "R1 miso idle", miso, 0);
    read_status(8'h00, "R1 status after reset");
    for (int a = 0; a < WORDS; a++) peek(a, '0, "R1 array zero");

    // R5 erase without latch
    cmd(8'h60);
    read_status(8'h00, "R5 no latch no erase");
    wait_clk(EC + 200);
    peek(0, '0, "R5 array untouched");

    // R2 write enable
    cmd(8'h06);
    read_status(8'h02, "R2 latch set");

    // R6 misaligned and short frames
    spi_frame(32'h600, 12, r);
    read_status(8'h02, "R6 12-bit frame rejected");
    spi_frame(32'h0C, 5, r);
    read_status(8'h02, "R6 5-bit frame rejected");
    peek(3, '0, "R6 array untouched");

    // R8 protection
    prot = 8'h10;
    cmd(8'hC7);
    read_status(8'h00, "R8 protected clears latch");
    prot = '0;
    wait_clk(EC + 200);
    peek(5, '0, "R8 array untouched");

    // R3 erase with 60h, R11 double read
    cmd(8'h06);
    cmd(8'h60);
    read_status2(8'h03, "R11 busy repeated read");
    read_status(8'h03, "R3 busy while erasing");
    wait_clk(EC + 200);
    read_status(8'h00, "R3 finished");
    peek(0, '1, "R3 word0 ones");
    peek(WORDS - 1, '1, "R3 last word ones");

    // R4 erase with C7h
    do_reset();
    peek(7, '0, "R4 zero before");
    cmd(8'h06);
    cmd(8'hC7);
    read_status(8'h03, "R4 busy");
    wait_clk(EC + 200);
    read_status(8'h00, "R4 finished");
    peek(7, '1, "R4 ones after");

    // R7 trailing byte ignored
    do_reset();
    cmd(8'h06);
    spi_frame(32'h60AA, 16, r);
    read_status(8'h03, "R7 erase with trailing byte");
    wait_clk(EC + 200);
    read_status(8'h00, "R7 finished");
    peek(2, '1, "R7 ones after");

    // R9 failure injection
    cmd(8'h06);
    inj = 1;
    cmd(8'h60);
    wait_clk(EC + 200);
    read_status(8'h20, "R9 error flag set");
    inj = 0;
    cmd(8'h06);
    read_status(8'h22, "R9 error flag kept with latch");
    cmd(8'h60);
    read_status(8'h03, "R9 error cleared on launch");
    wait_clk(EC + 200);
    read_status(8'h00, "R9 clean finish");

    // R10 commands ignored while busy
    cmd(8'h06);
    cmd(8'h60);
    read_status(8'h03, "R10 busy");
    wait_clk(1500);
    cmd(8'hC7);
    cmd(8'h06);
    read_status(8'h03, "R10 still busy");
    wait_clk(2000);
    read_status(8'h00, "R10 no restart");

    wait_clk(20);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule